// File: doc/BRIEF.md
# Command-Word FIFO SPI Master

This block is an SPI master that the host drives entirely through 32-bit command words. Each word goes into a four-entry transmit queue and carries three things: one data frame, a one-hot mask that picks the chip-select line, and a continue flag. The continue flag decides whether that line stays asserted once the frame is done. A multi-byte SPI transaction is therefore a run of independent queue entries. Every entry except the last sets the continue flag.

Each frame that is shifted out also shifts one frame in. The received frame goes into a four-entry receive queue, and the host pops it from the low 16 bits of `pop_data`. A status word reports how full both queues are, together with a sticky overflow flag. Configuration inputs set the frame length, clock polarity and phase, the baud divider and the idle level of each chip-select line. The intended default is SPI mode 3 with every select idling high. The bench drives `miso` from `mosi` in loopback.

Top module: `cmdspi_master`

## Requirements
- R1: A command word is laid out as follows: bit 31 is the continue flag, bits 23:16 are the select mask and bits 15:0 are the data. A frame sends the low N data bits, MSB first, where N = `cfg_frame_size` + 1 (7 gives 8 bits). Data bits above N are ignored.
- R2: Each SCK half period lasts `cfg_div`+1 system clocks, so SCK runs at clk/(2·(`cfg_div`+1)). While no frame is active, SCK sits at `cfg_cpol`. During shift half k (counted from 0), SCK equals cpol XOR cpha XOR (k mod 2). MOSI holds bit i during halves 2i and 2i+1.
- R3: Setting bit j of the mask asserts line j: `cs_n[j]` is driven to the inverse of `cfg_cs_idle[j]`. Every other line stays at its idle level. The selected line goes active 2·(`cfg_div`+1) clocks before the first shift half, and MOSI already shows the MSB during that time.
- R4: With the continue flag at 1, the line stays active after the frame ends. With it at 0, every line returns to its idle level in the first cycle after the last shift half.
- R5: If a frame's mask differs from the mask that is still held active, all lines sit at their idle level for exactly 2·(`cfg_div`+1) clocks before the new line asserts.
- R6: Each frame pushes one entry into the receive queue when its last half ends. The entry holds the N bits sampled from MISO, with zeros above them. MISO is sampled at the clock that ends each even half. If the receive queue is full, the entry is dropped.
- R7: `pop_data` shows the oldest receive entry, or 0 when the receive queue is empty. Raising `pop_req` removes that entry at the clock edge.
- R8: The transmit queue holds 4 entries. A push into a full queue is dropped and sets status bit 0, which stays set.
- R9: Status bits 15:12 hold the transmit queue count and bits 7:4 hold the receive queue count. Every other bit except bit 0 reads 0.
- R10: `flush_tx` empties the transmit queue and clears the overflow flag. `flush_rx` empties the receive queue. A flush overrides any push, pop or frame start in the same cycle.
- R11: After reset both queues are empty, status reads 0, SCK equals `cfg_cpol`, MOSI is 0 and `cs_n` equals `cfg_cs_idle`.
- R12: The engine takes the next queued word at the first clock edge where it is idle and the queue is non-empty. Back-to-back frames are therefore separated by exactly one idle cycle, which is visible as a one-cycle release between frames on the same line when the continue flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Push `push_word` into the transmit queue |
| push_word | input | 32 | Command word: continue flag, select mask, data |
| pop_req | input | 1 | Remove the oldest receive entry |
| pop_data | output | 16 | Oldest receive entry, 0 when empty |
| flush_tx | input | 1 | Empty the transmit queue and clear overflow |
| flush_rx | input | 1 | Empty the receive queue |
| cfg_frame_size | input | 4 | Bits per frame minus one |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_div | input | 8 | Baud divider; half period is cfg_div+1 clocks |
| cfg_cs_idle | input | 8 | Idle level of each chip-select line |
| status | output | 32 | Queue counts and overflow flag |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Chip-select lines |

## Verification
The hardest situation to reach is a select swap. A frame must arrive with a new mask while an earlier continued frame still holds a different line active. Only then does the release window open. The bench reaches it by pushing a continue-flagged word for line 0 and then, straight after, a word for line 2, and it counts the all-idle cycles between the two frames. Queue saturation is also hard to reach from the ports: receive entries must be allowed to pile up unread, and pushes must be spaced so that the transmit queue fills faster than a slow divider can drain it.

// File: rtl/cmdspi_pkg.sv
// Package cmdspi_pkg: shared types for the command-word SPI master.
// Assumes 16-bit frames at most and 8 chip-select lines.
package cmdspi_pkg;
    localparam int DATA_W = 16;
    localparam int CS_W   = 8;

    // Fields of a queued command word that the engine uses
    typedef struct packed {
        logic              cont;
        logic [CS_W-1:0]   mask;
        logic [DATA_W-1:0] data;
    } cmd_t;

    // Engine segment within one frame
    typedef enum logic [1:0] {
        SEG_REL   = 2'd0,
        SEG_SETUP = 2'd1,
        SEG_SHIFT = 2'd2
    } seg_t;
endpackage

// File: rtl/cmdspi_fifo.sv
// Module cmdspi_fifo: synchronous FIFO with a flush input and a zero head when empty.
// Assumes one push and one pop per cycle. A full FIFO drops the push and an empty
// FIFO ignores the pop. Flush has priority over both.
module cmdspi_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !flush && !full;
    assign do_pop  = pop && !flush && !empty;
    assign count   = cnt_q;
    assign head    = empty ? '0 : mem[rd_q];

    // Pointer wrap helper
    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/cmdspi_engine.sv
// Module cmdspi_engine: runs one SPI frame per start pulse. The frame has an
// optional release segment (a select swap), a one-SCK-period setup, and 2N shift halves.
// Assumes start is asserted only while busy is low.
module cmdspi_engine
    import cmdspi_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int FSZ_W = 4,
    localparam int KW   = FSZ_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_t              cmd,
    input  logic [FSZ_W-1:0]  cfg_frame_size,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi,
    output logic [CS_W-1:0]   cs_active
);
    seg_t              seg_q;
    logic              busy_q, cpol_q, cpha_q, cont_q, cs_on_q;
    logic [DIV_W-1:0]  hcnt_q, div_q;
    logic [KW-1:0]     k_q;
    logic [FSZ_W-1:0]  fsz_q, bit_idx;
    logic [CS_W-1:0]   mask_q;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic              half_end, last_half;

    assign half_end  = (hcnt_q == div_q);
    assign last_half = (k_q == {fsz_q, 1'b1});
    assign done      = busy_q && (seg_q == SEG_SHIFT) && half_end && last_half;
    assign busy      = busy_q;
    assign rx_word   = rx_q;
    assign bit_idx   = fsz_q - FSZ_W'(k_q >> 1);

    // Frame sequencing: latch command and configuration, step halves, capture MISO
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q   <= SEG_SETUP;
            busy_q  <= 1'b0;
            hcnt_q  <= '0;
            k_q     <= '0;
            div_q   <= '0;
            fsz_q   <= '0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            cont_q  <= 1'b0;
            cs_on_q <= 1'b0;
            mask_q  <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
        end else if (start) begin
            seg_q   <= (cs_on_q && (mask_q != cmd.mask)) ? SEG_REL : SEG_SETUP;
            busy_q  <= 1'b1;
            hcnt_q  <= '0;
            k_q     <= '0;
            div_q   <= cfg_div;
            fsz_q   <= cfg_frame_size;
            cpol_q  <= cfg_cpol;
            cpha_q  <= cfg_cpha;
            cont_q  <= cmd.cont;
            cs_on_q <= 1'b1;
            mask_q  <= cmd.mask;
            tx_q    <= cmd.data;
            rx_q    <= '0;
        end else if (busy_q) begin
            if (!half_end) begin
                hcnt_q <= hcnt_q + 1'b1;
            end else begin
                hcnt_q <= '0;
                if (seg_q == SEG_SHIFT) begin
                    if (!k_q[0]) rx_q <= {rx_q[DATA_W-2:0], miso};
                    if (last_half) begin
                        busy_q  <= 1'b0;
                        cs_on_q <= cont_q;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end else if (k_q[0]) begin
                    k_q   <= '0;
                    seg_q <= (seg_q == SEG_REL) ? SEG_SETUP : SEG_SHIFT;
                end else begin
                    k_q <= k_q + 1'b1;
                end
            end
        end
    end

    // Pin decode from state
    always_comb begin
        if (busy_q && seg_q == SEG_SHIFT) sck = cpol_q ^ cpha_q ^ k_q[0];
        else if (busy_q)                  sck = cpol_q;
        else                              sck = cfg_cpol;
        mosi      = (busy_q && seg_q != SEG_REL) ? tx_q[bit_idx] : 1'b0;
        cs_active = ((busy_q && seg_q == SEG_REL) || !cs_on_q) ? '0 : mask_q;
    end
endmodule

// File: rtl/cmdspi_master.sv
// Module cmdspi_master: a command-word SPI master built from a transmit FIFO, a frame
// engine and a receive FIFO. Assumes DEPTH <= 15 so each count fits its 4-bit status field.
module cmdspi_master
    import cmdspi_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DIV_W = 8,
    parameter int FSZ_W = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [31:0]       push_word,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    input  logic              flush_tx,
    input  logic              flush_rx,
    input  logic [FSZ_W-1:0]  cfg_frame_size,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [CS_W-1:0]   cfg_cs_idle,
    output logic [31:0]       status,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_W-1:0]   cs_n
);
    cmd_t            push_cmd, head_cmd;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            eng_busy, eng_done, eng_start, ovf_q;
    logic [DATA_W-1:0] eng_rx;
    logic [CS_W-1:0] cs_active;

    assign push_cmd  = '{cont: push_word[31], mask: push_word[23:16], data: push_word[15:0]};
    assign eng_start = !eng_busy && !tx_empty && !flush_tx;
    assign cs_n      = cfg_cs_idle ^ cs_active;
    assign status    = {16'h0, 4'(tx_cnt), 4'h0, 4'(rx_cnt), 3'b000, ovf_q};

    cmdspi_fifo #(.W($bits(cmd_t)), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(push_valid), .push_data(push_cmd),
        .pop(eng_start), .flush(flush_tx), .head(head_cmd), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    cmdspi_engine #(.DIV_W(DIV_W), .FSZ_W(FSZ_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .cmd(head_cmd),
        .cfg_frame_size(cfg_frame_size), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .miso(miso), .busy(eng_busy), .done(eng_done),
        .rx_word(eng_rx), .sck(sck), .mosi(mosi), .cs_active(cs_active)
    );

    cmdspi_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(eng_done), .push_data(eng_rx),
        .pop(pop_req), .flush(flush_rx), .head(pop_data), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    // Sticky overflow flag for pushes into a full transmit queue
    always_ff @(posedge clk) begin
        if (!rst_n || flush_tx)          ovf_q <= 1'b0;
        else if (push_valid && tx_full)  ovf_q <= 1'b1;
    end
endmodule

// File: rtl/cmdspi_checker.sv
// Module cmdspi_checker: port-level properties of cmdspi_master, attached by bind.
module cmdspi_checker #(
    parameter int DEPTH = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_tx,
    input logic        cfg_cpol,
    input logic [7:0]  cfg_cs_idle,
    input logic [7:0]  cs_n,
    input logic        sck,
    input logic [31:0] status,
    input logic [15:0] pop_data,
    input logic        eng_busy
);
    logic [7:0] act;
    assign act = cs_n ^ cfg_cs_idle;

    AST_POP_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] == 4'd0 |-> pop_data == 16'd0); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !flush_tx) |=> status[0]); // R8
    AST_TX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:12] <= 4'(DEPTH)); // R8
    AST_FLUSH_TX: assert property (@(posedge clk) disable iff (!rst_n)
        flush_tx |=> (status[15:12] == 4'd0 && !status[0])); // R10
    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> sck == cfg_cpol); // R2
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act)); // R3
    AST_CS_SWAP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cfg_cs_idle) && act != 8'd0 && $past(act) != 8'd0) |-> act == $past(act)); // R5
    AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[31:16] == 16'd0 && status[11:8] == 4'd0 && status[3:1] == 3'd0)); // R9
endmodule

bind cmdspi_master cmdspi_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush_tx(flush_tx), .cfg_cpol(cfg_cpol),
    .cfg_cs_idle(cfg_cs_idle), .cs_n(cs_n), .sck(sck), .status(status),
    .pop_data(pop_data), .eng_busy(eng_busy)
);

// File: tb/sim_cmdspi_master.sv
// Bench for cmdspi_master: a behavioural queue/integer model compared every clock,
// plus directed checks of the boundary cases. MISO is looped back from MOSI.
module sim_cmdspi_master;
    localparam int DEPTH = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        push_valid = 1'b0, pop_req = 1'b0, flush_tx = 1'b0, flush_rx = 1'b0;
    logic [31:0] push_word = '0;
    logic [3:0]  cfg_frame_size = 4'd7;
    logic        cfg_cpol = 1'b1, cfg_cpha = 1'b1;
    logic [7:0]  cfg_div = 8'd1, cfg_cs_idle = 8'hFF;
    logic [15:0] pop_data;
    logic [31:0] status;
    logic        sck, mosi, miso;
    logic [7:0]  cs_n;

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;

    assign miso = mosi;
    always #4 clk = ~clk;

    cmdspi_master u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
        .pop_req(pop_req), .pop_data(pop_data), .flush_tx(flush_tx), .flush_rx(flush_rx),
        .cfg_frame_size(cfg_frame_size), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_div(cfg_div), .cfg_cs_idle(cfg_cs_idle), .status(status), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_txq[$];
    logic [15:0] m_rxq[$];
    bit   m_ready = 0, m_busy = 0, m_held_on = 0, m_ovf = 0, m_cont = 0, m_cpol = 0, m_cpha = 0;
    logic [7:0]  m_held_mask = '0, m_mask = '0;
    logic [15:0] m_data = '0;
    int   m_e = 0, m_f = 0, m_r = 0, m_h = 1, m_n = 1;

    always @(posedge clk) begin
        int pre_tx, pre_rx;
        bit done_m, start_m;
        logic [31:0] w;
        if (!rst_n) begin
            m_txq.delete(); m_rxq.delete();
            m_busy = 0; m_held_on = 0; m_held_mask = '0; m_ovf = 0; m_e = 0; m_ready = 1;
        end else begin
            pre_tx  = m_txq.size();
            pre_rx  = m_rxq.size();
            done_m  = m_busy && (m_e == m_f - 1);
            start_m = !m_busy && pre_tx > 0 && !flush_tx;
            if (m_busy) begin
                if (done_m) begin m_busy = 0; m_held_on = m_cont; end
                else m_e++;
            end
            if (flush_rx) m_rxq.delete();
            else begin
                if (pop_req && pre_rx > 0) void'(m_rxq.pop_front());
                if (done_m && pre_rx < DEPTH)
                    m_rxq.push_back(16'(int'(m_data) % (1 << m_n)));
            end
            if (start_m) begin
                w = m_txq[0];
                m_n = int'(cfg_frame_size) + 1;
                m_h = int'(cfg_div) + 1;
                m_cpol = cfg_cpol; m_cpha = cfg_cpha;
                m_data = w[15:0]; m_mask = w[23:16]; m_cont = w[31];
                m_r = (m_held_on && m_held_mask != m_mask) ? 2 * m_h : 0;
                m_f = m_r + 2 * m_h + 2 * m_n * m_h;
                m_e = 0; m_busy = 1; m_held_mask = m_mask; m_held_on = 1;
            end
            if (flush_tx) begin m_txq.delete(); m_ovf = 0; end
            else begin
                if (start_m) void'(m_txq.pop_front());
                if (push_valid) begin
                    if (pre_tx < DEPTH) m_txq.push_back(push_word);
                    else m_ovf = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        logic e_sck, e_mosi;
        logic [7:0] e_act;
        int s, k;
        if (rst_n && m_ready && !done_flag) begin
            if (!m_busy) begin
                e_sck = cfg_cpol; e_mosi = 1'b0; e_act = m_held_on ? m_held_mask : 8'h00;
            end else if (m_e < m_r) begin
                e_sck = m_cpol; e_mosi = 1'b0; e_act = 8'h00;
            end else if (m_e < m_r + 2 * m_h) begin
                e_sck = m_cpol; e_mosi = m_data[m_n-1]; e_act = m_mask;
            end else begin
                s = m_e - m_r - 2 * m_h; k = s / m_h;
                e_sck = m_cpol ^ m_cpha ^ (k % 2 == 1);
                e_mosi = m_data[m_n - 1 - k / 2];
                e_act = m_mask;
            end
            check("R2 sck", {31'd0, sck}, {31'd0, e_sck});
            check("R1 mosi", {31'd0, mosi}, {31'd0, e_mosi});
            check("R3 cs_n (R4 R5 R12 timing)", {24'd0, cs_n}, {24'd0, cfg_cs_idle ^ e_act});
            check("R9 status", status, {16'h0, 4'(m_txq.size()), 4'h0, 4'(m_rxq.size()), 3'b000, m_ovf});
            check("R7 pop_data", {16'd0, pop_data}, {16'd0, (m_rxq.size() > 0) ? m_rxq[0] : 16'h0});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic push(input logic [31:0] w);
        @(posedge clk); #2; push_valid = 1'b1; push_word = w;
        @(posedge clk); #2; push_valid = 1'b0;
    endtask

    task automatic pop_expect(input string tag, input logic [15:0] exp);
        @(posedge clk); #2;
        check(tag, {16'd0, pop_data}, {16'd0, exp});
        pop_req = 1'b1;
        @(posedge clk); #2; pop_req = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_flush(input bit tx, input bit rx);
        @(posedge clk); #2; flush_tx = tx; flush_rx = rx;
        @(posedge clk); #2; flush_tx = 1'b0; flush_rx = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        int gap;
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 status", status, 32'h0);
        check("R11 cs_n", {24'd0, cs_n}, 32'hFF);
        check("R11 sck", {31'd0, sck}, 32'd1);
        check("R11 mosi", {31'd0, mosi}, 32'd0);

        // Mode 3, 8-bit frames, multi-word transaction on line 1
        push(32'h8002_009F); push(32'h8002_0000); push(32'h0002_0055);
        settle(200);
        check("R6 rx count", {28'd0, status[7:4]}, 32'd3);
        check("R4 released after last", {24'd0, cs_n}, 32'hFF);
        pop_expect("R6 rx0", 16'h009F);
        pop_expect("R6 rx1", 16'h0000);
        pop_expect("R6 rx2", 16'h0055);
        pop_expect("R7 empty pop", 16'h0000);

        // R4 continue flag holds the line
        push(32'h8002_00C3); settle(100);
        check("R4 held", {24'd0, cs_n}, 32'hFD);
        push(32'h0002_003C); settle(100);
        check("R4 released", {24'd0, cs_n}, 32'hFF);
        pop_expect("R6 rx held", 16'h00C3);
        pop_expect("R6 rx end", 16'h003C);

        // R12 one idle cycle between frames on the same line
        push(32'h0002_00A1); push(32'h0002_00B2);
        while (cs_n[1] !== 1'b0) @(negedge clk);
        while (cs_n[1] !== 1'b1) @(negedge clk);
        gap = 0;
        while (cs_n[1] !== 1'b0) begin gap++; @(negedge clk); end
        check("R12 gap", gap, 32'd1);
        settle(100);
        pulse_flush(1'b0, 1'b1);
        check("R10 rx flushed", {28'd0, status[7:4]}, 32'd0);

        // R1 mode 0, fastest divider, 16- and 5-bit frames
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 8'd0; cfg_frame_size = 4'd15;
        push(32'h0001_A5C3); settle(60);
        pop_expect("R1 16-bit", 16'hA5C3);
        cfg_frame_size = 4'd4;
        push(32'h0001_00FF); settle(40);
        pop_expect("R1 5-bit", 16'h001F);

        // R5 select swap while held
        cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 8'd1; cfg_frame_size = 4'd7;
        push(32'h8001_0011); push(32'h0004_0022);
        while (cs_n[0] !== 1'b0) @(negedge clk);
        while (cs_n[0] !== 1'b1) @(negedge clk);
        gap = 0;
        while (cs_n[2] !== 1'b0) begin
            if (cs_n == 8'hFF) gap++;
            @(negedge clk);
        end
        check("R5 release gap", gap, 32'd4);
        settle(100);
        pop_expect("R6 swap rx0", 16'h0011);
        pop_expect("R6 swap rx1", 16'h0022);

        // R8 overflow and R10 flush of transmit queue
        cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_div = 8'd3;
        for (int i = 0; i < 6; i++) push(32'h0002_0040 + i);
        @(negedge clk);
        check("R8 tx count", {28'd0, status[15:12]}, 32'd4);
        check("R8 overflow", {31'd0, status[0]}, 32'd1);
        pulse_flush(1'b1, 1'b0);
        check("R10 tx flushed", {28'd0, status[15:12]}, 32'd0);
        check("R10 overflow cleared", {31'd0, status[0]}, 32'd0);
        settle(120);
        pulse_flush(1'b0, 1'b1);

        // R6 receive queue saturates and drops
        cfg_div = 8'd0;
        for (int i = 0; i < 5; i++) begin push(32'h0002_0060 + i); settle(30); end
        check("R6 rx full", {28'd0, status[7:4]}, 32'd4);
        pop_expect("R6 oldest kept", 16'h0060);
        pulse_flush(1'b0, 1'b1);

        // R3 per-line idle level
        cfg_cs_idle = 8'hF7; settle(2);
        check("R3 idle low", {24'd0, cs_n}, 32'hF7);
        push(32'h0008_0012);
        gap = 0;
        while (cs_n[3] !== 1'b1 && gap < 50) begin gap++; @(negedge clk); end
        check("R3 active high", {31'd0, cs_n[3]}, 32'd1);
        settle(40);
        check("R3 back to idle", {24'd0, cs_n}, 32'hF7);
        pop_expect("R6 rx idle-low line", 16'h0012);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule